// File: doc/BRIEF.md
# Integer ALU with Immediate Operand Forms

This block is the integer execute stage of a 32-bit RISC core whose register 0 is hardwired to zero. In a single combinational pass it performs arithmetic, bitwise logic, set-on-compare, shift, rotate and multiply operations. Operand B comes either from the register file or from the 16-bit immediate field of the instruction.

How the immediate is extended depends on the operation:

- Arithmetic and signed compares sign-extend it.
- Bitwise logic and unsigned compares zero-extend it.
- The "high" logic forms move the immediate into the upper half-word.

The decode stage supplies the operation code, both source register indices with the values read for them, the immediate, a 5-bit shift-immediate field and the destination index. The block returns the result together with a register-file write enable. That write enable is withheld when the destination is register 0.

Top module: `alu_core`

## Requirements
- R1: A source index of 0 makes that operand read as zero, whatever value is presented on its value input.
- R2: `wr_en_o` equals `exec_i` AND (`dst_i` != 0).
- R3: ADD (code 0) and SUB (code 1) wrap modulo 2^32, with no overflow indication.
- R4: With `b_imm_i`=1, ADD, MUL (code 2) and the signed compares GE/LT/NE/EQ (codes 7..10) use the 16-bit immediate sign-extended to 32 bits.
- R5: With `b_imm_i`=1, AND/OR/XOR (codes 3,4,5) and the unsigned compares GEU/LTU (codes 11,12) use the immediate zero-extended. When `imm_hi_i`=1 on a logic operation, the immediate is instead placed in bits 31:16 and bits 15:0 are zero.
- R6: Compare codes 7..12 (GE, LT, NE, EQ, GEU, LTU of A against B) produce 1 when true and 0 when false. GE and LT treat operands as signed; GEU and LTU treat them as unsigned.
- R7: AND, OR, XOR and NOR (code 6) are bitwise on A and B.
- R8: Register-amount shifts and rotates use only B[4:0] as the amount: SLL 13, SRL 14, SRA 15 (arithmetic), ROL 16, ROR 17.
- R9: With `b_imm_i`=1, a shift or rotate takes its amount from `shamt_i`.
- R10: MUL returns the low 32 bits of A×B.
- R11: MULHSS (18), MULHUU (19) and MULHSU (20) return bits 63:32 of the 64-bit product, for signed×signed, unsigned×unsigned and signed A × unsigned B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (values listed in the requirements) |
| a_idx_i | input | 5 | Source A register index |
| a_val_i | input | 32 | Value read for source A |
| b_idx_i | input | 5 | Source B register index |
| b_val_i | input | 32 | Value read for source B |
| b_imm_i | input | 1 | 1: operand B / shift amount from the immediate fields |
| imm_i | input | 16 | Instruction immediate |
| imm_hi_i | input | 1 | Place the immediate in the upper half (logic ops) |
| shamt_i | input | 5 | Shift-immediate field |
| exec_i | input | 1 | Instruction valid in this stage |
| dst_i | input | 5 | Destination register index |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Register-file write enable |

## Verification
The assertions assume that `op_i` always carries one of the 21 defined codes. They also assume that `imm_hi_i` is raised only together with `b_imm_i` on an AND, OR or XOR; several checks, such as the zero low half of a high immediate, depend on this. The random stimulus draws codes only from that defined range and clears `imm_hi_i` whenever the chosen operation is not a logic operation. Register indices of 0, all-ones and sign-boundary operand values are also injected on purpose, because they are the cases that separate sign from zero extension.

// File: rtl/alu_pkg.sv
package alu_pkg;
    parameter int XLEN  = 32;
    parameter int IMMW  = 16;
    parameter int RIDXW = 5;
    localparam int SHW  = $clog2(XLEN);
    localparam int OPW  = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_MUL    = 5'd2,
        OP_AND    = 5'd3,
        OP_OR     = 5'd4,
        OP_XOR    = 5'd5,
        OP_NOR    = 5'd6,
        OP_CGE    = 5'd7,
        OP_CLT    = 5'd8,
        OP_CNE    = 5'd9,
        OP_CEQ    = 5'd10,
        OP_CGEU   = 5'd11,
        OP_CLTU   = 5'd12,
        OP_SLL    = 5'd13,
        OP_SRL    = 5'd14,
        OP_SRA    = 5'd15,
        OP_ROL    = 5'd16,
        OP_ROR    = 5'd17,
        OP_MULHSS = 5'd18,
        OP_MULHUU = 5'd19,
        OP_MULHSU = 5'd20
    } op_e;

    typedef enum logic [2:0] {
        SK_SLL, SK_SRL, SK_SRA, SK_ROL, SK_ROR
    } shift_kind_e;

    typedef logic [XLEN-1:0] word_t;

    // Immediate is sign-extended for arithmetic and signed compares.
    function automatic logic imm_is_signed(op_e op);
        return op inside {OP_ADD, OP_SUB, OP_MUL, OP_CGE, OP_CLT, OP_CNE, OP_CEQ};
    endfunction

    function automatic logic is_logic(op_e op);
        return op inside {OP_AND, OP_OR, OP_XOR, OP_NOR};
    endfunction

    function automatic logic is_compare(op_e op);
        return op inside {OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU};
    endfunction

    function automatic logic is_shift(op_e op);
        return op inside {OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR};
    endfunction
endpackage

// File: rtl/alu_operand.sv
module alu_operand
    import alu_pkg::*;
(
    input  op_e              op_i,
    input  logic [RIDXW-1:0] a_idx_i,
    input  word_t            a_val_i,
    input  logic [RIDXW-1:0] b_idx_i,
    input  word_t            b_val_i,
    input  logic             b_imm_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic             imm_hi_i,
    output word_t            a_o,
    output word_t            b_o
);
    localparam int PADW = XLEN - IMMW;

    word_t imm_ext;

    always_comb begin
        if (imm_hi_i && is_logic(op_i))
            imm_ext = word_t'({imm_i, {IMMW{1'b0}}});
        else if (imm_is_signed(op_i))
            imm_ext = {{PADW{imm_i[IMMW-1]}}, imm_i};
        else
            imm_ext = {{PADW{1'b0}}, imm_i};
    end

    assign a_o = (a_idx_i == '0) ? '0 : a_val_i;
    assign b_o = b_imm_i ? imm_ext : ((b_idx_i == '0) ? '0 : b_val_i);

    // R5: a high immediate leaves the low half-word clear
    always_comb begin
        if (b_imm_i && imm_hi_i && is_logic(op_i))
            a_r5_hi_low_zero: assert (b_o[IMMW-1:0] == '0);
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
(
    input  shift_kind_e    kind_i,
    input  word_t          val_i,
    input  logic [SHW-1:0] amt_i,
    output word_t          res_o
);
    always_comb begin
        unique case (kind_i)
            SK_SLL:  res_o = val_i << amt_i;
            SK_SRL:  res_o = val_i >> amt_i;
            SK_SRA:  res_o = word_t'($signed(val_i) >>> amt_i);
            SK_ROL:  res_o = (val_i << amt_i) | (val_i >> (XLEN - int'(amt_i)));
            SK_ROR:  res_o = (val_i >> amt_i) | (val_i << (XLEN - int'(amt_i)));
            default: res_o = val_i;
        endcase
    end

    // R8: a zero-amount rotate returns its input unchanged
    always_comb begin
        if ((kind_i == SK_ROL || kind_i == SK_ROR) && amt_i == '0)
            a_r8_rot_zero_identity: assert (res_o == val_i);
    end
endmodule

// File: rtl/alu_mulhi.sv
module alu_mulhi
    import alu_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  logic  a_signed_i,
    input  logic  b_signed_i,
    output word_t hi_o
);
    localparam int EW = XLEN + 1;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] a_ext, b_ext;
    logic signed [PW-1:0] prod;

    assign a_ext = {a_signed_i & a_i[XLEN-1], a_i};
    assign b_ext = {b_signed_i & b_i[XLEN-1], b_i};
    assign prod  = a_ext * b_ext;
    assign hi_o  = prod[2*XLEN-1:XLEN];

    // R11: a zero factor gives a zero upper word
    always_comb begin
        if (a_i == '0 || b_i == '0)
            a_r11_zero_factor: assert (hi_o == '0);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  logic [OPW-1:0]   op_i,
    input  logic [RIDXW-1:0] a_idx_i,
    input  logic [XLEN-1:0]  a_val_i,
    input  logic [RIDXW-1:0] b_idx_i,
    input  logic [XLEN-1:0]  b_val_i,
    input  logic             b_imm_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic             imm_hi_i,
    input  logic [SHW-1:0]   shamt_i,
    input  logic             exec_i,
    input  logic [RIDXW-1:0] dst_i,
    output logic [XLEN-1:0]  result_o,
    output logic             wr_en_o
);
    op_e         op;
    word_t       opa, opb, sh_res, mh_res;
    shift_kind_e sk;
    logic [SHW-1:0] amt;
    logic        mh_as, mh_bs;

    assign op = op_e'(op_i);

    alu_operand u_opnd (
        .op_i    (op),
        .a_idx_i (a_idx_i),
        .a_val_i (a_val_i),
        .b_idx_i (b_idx_i),
        .b_val_i (b_val_i),
        .b_imm_i (b_imm_i),
        .imm_i   (imm_i),
        .imm_hi_i(imm_hi_i),
        .a_o     (opa),
        .b_o     (opb)
    );

    always_comb begin
        unique case (op)
            OP_SRL:  sk = SK_SRL;
            OP_SRA:  sk = SK_SRA;
            OP_ROL:  sk = SK_ROL;
            OP_ROR:  sk = SK_ROR;
            default: sk = SK_SLL;
        endcase
    end

    assign amt = b_imm_i ? shamt_i : opb[SHW-1:0];

    alu_shift u_shift (
        .kind_i(sk),
        .val_i (opa),
        .amt_i (amt),
        .res_o (sh_res)
    );

    assign mh_as = (op == OP_MULHSS) || (op == OP_MULHSU);
    assign mh_bs = (op == OP_MULHSS);

    alu_mulhi u_mulhi (
        .a_i       (opa),
        .b_i       (opb),
        .a_signed_i(mh_as),
        .b_signed_i(mh_bs),
        .hi_o      (mh_res)
    );

    always_comb begin
        result_o = '0;
        unique case (op)
            OP_ADD:  result_o = opa + opb;
            OP_SUB:  result_o = opa - opb;
            OP_MUL:  result_o = opa * opb;
            OP_AND:  result_o = opa & opb;
            OP_OR:   result_o = opa | opb;
            OP_XOR:  result_o = opa ^ opb;
            OP_NOR:  result_o = ~(opa | opb);
            OP_CGE:  result_o = word_t'($signed(opa) >= $signed(opb));
            OP_CLT:  result_o = word_t'($signed(opa) <  $signed(opb));
            OP_CNE:  result_o = word_t'(opa != opb);
            OP_CEQ:  result_o = word_t'(opa == opb);
            OP_CGEU: result_o = word_t'(opa >= opb);
            OP_CLTU: result_o = word_t'(opa <  opb);
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR: result_o = sh_res;
            OP_MULHSS, OP_MULHUU, OP_MULHSU:        result_o = mh_res;
            default: result_o = '0;
        endcase
    end

    assign wr_en_o = exec_i && (dst_i != '0);

    // R2: destination 0 never gets a write
    always_comb begin
        if (dst_i == '0)
            a_r2_no_write_r0: assert (!wr_en_o);
    end

    // R6: compares yield only 0 or 1
    always_comb begin
        if (is_compare(op))
            a_r6_cmp_boolean: assert (result_o[XLEN-1:1] == '0);
    end

    // R3: a wrapped difference plus B gives back A
    always_comb begin
        if (op == OP_SUB)
            a_r3_sub_wraps: assert (result_o + opb == opa);
    end

    // R1: index 0 on A with OR of register zero yields zero
    always_comb begin
        if (op == OP_OR && a_idx_i == '0 && !b_imm_i && b_idx_i == '0)
            a_r1_zero_reg_reads_zero: assert (result_o == '0);
    end
endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;
    import alu_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [4:0]  op_i, a_idx_i, b_idx_i, shamt_i, dst_i;
    logic [31:0] a_val_i, b_val_i, result_o;
    logic        b_imm_i, imm_hi_i, exec_i, wr_en_o;
    logic [15:0] imm_i;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    alu_core u0 (
        .op_i(op_i), .a_idx_i(a_idx_i), .a_val_i(a_val_i),
        .b_idx_i(b_idx_i), .b_val_i(b_val_i), .b_imm_i(b_imm_i),
        .imm_i(imm_i), .imm_hi_i(imm_hi_i), .shamt_i(shamt_i),
        .exec_i(exec_i), .dst_i(dst_i), .result_o(result_o), .wr_en_o(wr_en_o)
    );

    function automatic string req_of(logic [4:0] op, logic sel);
        if (op <= 1)  return sel ? "R3/R4" : "R3";
        if (op == 2)  return sel ? "R10/R4" : "R10";
        if (op <= 6)  return sel ? "R7/R5" : "R7";
        if (op <= 10) return sel ? "R6/R4" : "R6";
        if (op <= 12) return sel ? "R6/R5" : "R6";
        if (op <= 17) return sel ? "R9" : "R8";
        return "R11";
    endfunction

    function automatic logic [31:0] model(
        logic [4:0] op, logic [4:0] ai, logic [31:0] av, logic [4:0] bi,
        logic [31:0] bv, logic sel, logic [15:0] im, logic hi, logic [4:0] sh);
        logic [31:0] a, b, r;
        logic [63:0] uu;
        logic [31:0] h;
        int s;
        a = (ai == 0) ? 32'd0 : av;
        if (sel) begin
            if (hi) b = {im, 16'd0};
            else if (op <= 2 || (op >= 7 && op <= 10)) b = {{16{im[15]}}, im};
            else b = {16'd0, im};
        end else b = (bi == 0) ? 32'd0 : bv;
        s = sel ? int'(sh) : int'(b[4:0]);
        uu = {32'd0, a} * {32'd0, b};
        h = uu[63:32];
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = uu[31:0];
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            6: r = ~(a | b);
            7: r = {31'd0, $signed(a) >= $signed(b)};
            8: r = {31'd0, $signed(a) < $signed(b)};
            9: r = {31'd0, a != b};
            10: r = {31'd0, a == b};
            11: r = {31'd0, a >= b};
            12: r = {31'd0, a < b};
            13: r = a << s;
            14: r = a >> s;
            15: begin r = a; for (int k = 0; k < s; k++) r = {r[31], r[31:1]}; end
            16: begin r = a; for (int k = 0; k < s; k++) r = {r[30:0], r[31]}; end
            17: begin r = a; for (int k = 0; k < s; k++) r = {r[0], r[31:1]}; end
            18: r = h - (a[31] ? b : 32'd0) - (b[31] ? a : 32'd0);
            19: r = h;
            20: r = h - (a[31] ? b : 32'd0);
            default: r = 32'd0;
        endcase
        return r;
    endfunction

    task automatic apply(logic [4:0] op, logic [4:0] ai, logic [31:0] av,
                         logic [4:0] bi, logic [31:0] bv, logic sel,
                         logic [15:0] im, logic hi, logic [4:0] sh,
                         logic ex, logic [4:0] d);
        logic [31:0] exp_r;
        logic exp_w;
        @(negedge clk);
        op_i = op; a_idx_i = ai; a_val_i = av; b_idx_i = bi; b_val_i = bv;
        b_imm_i = sel; imm_i = im; imm_hi_i = hi; shamt_i = sh;
        exec_i = ex; dst_i = d;
        #2;
        exp_r = model(op, ai, av, bi, bv, sel, im, hi, sh);
        exp_w = ex && (d != 0);
        n_run++;
        if (result_o !== exp_r) begin
            n_fail++;
            $display("FAIL %s op=%0d result actual=%h expected=%h",
                     req_of(op, sel), op, result_o, exp_r);
        end
        n_run++;
        if (wr_en_o !== exp_w) begin
            n_fail++;
            $display("FAIL R2 wr_en actual=%b expected=%b", wr_en_o, exp_w);
        end
    endtask

    task automatic expect_val(string req, logic [31:0] exp_r);
        n_run++;
        if (result_o !== exp_r) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, result_o, exp_r);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        op_i = 0; a_idx_i = 0; a_val_i = 0; b_idx_i = 0; b_val_i = 0;
        b_imm_i = 0; imm_i = 0; imm_hi_i = 0; shamt_i = 0; exec_i = 0; dst_i = 0;
        repeat (2) @(posedge clk);

        // Idle state: nothing enabled, zero operands
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: index 0 ignores the presented value
        apply(4, 0, 32'hDEAD_BEEF, 0, 32'h1234_5678, 0, 0, 0, 0, 1, 3);
        expect_val("R1 zero-reg OR", 32'd0);
        // R2: exec with dst 0
        apply(0, 1, 5, 2, 6, 0, 0, 0, 0, 1, 0);
        // R3: wrap
        apply(0, 1, 32'hFFFF_FFFF, 2, 32'd1, 0, 0, 0, 0, 1, 1);
        expect_val("R3 add wrap", 32'd0);
        apply(1, 1, 32'd0, 2, 32'd1, 0, 0, 0, 0, 1, 1);
        expect_val("R3 sub wrap", 32'hFFFF_FFFF);
        // R4: sign-extended add immediate
        apply(0, 1, 32'd10, 0, 0, 1, 16'hFFFF, 0, 0, 1, 1);
        expect_val("R4 addi -1", 32'd9);
        // R5: zero-extended and, high form
        apply(3, 1, 32'hFFFF_FFFF, 0, 0, 1, 16'h8001, 0, 0, 1, 1);
        expect_val("R5 andi zext", 32'h0000_8001);
        apply(4, 1, 32'h0000_0F0F, 0, 0, 1, 16'hA5A5, 1, 0, 1, 1);
        expect_val("R5 orhi", 32'hA5A5_0F0F);
        // R6: signed vs unsigned compares against immediate -1
        apply(8, 1, 32'd0, 0, 0, 1, 16'hFFFF, 0, 0, 1, 1);
        expect_val("R6 lt signed", 32'd0);
        apply(12, 1, 32'd0, 0, 0, 1, 16'hFFFF, 0, 0, 1, 1);
        expect_val("R6 ltu", 32'd1);
        // R7: NOR
        apply(6, 1, 32'hF0F0_0000, 2, 32'h0F0F_0000, 0, 0, 0, 0, 1, 1);
        expect_val("R7 nor", 32'h0000_FFFF);
        // R8: amount masked to 5 bits
        apply(13, 1, 32'd1, 2, 32'd33, 0, 0, 0, 0, 1, 1);
        expect_val("R8 sll mask", 32'd2);
        apply(15, 1, 32'h8000_0000, 2, 32'hFFFF_FFE4, 0, 0, 0, 0, 1, 1);
        expect_val("R8 sra", 32'hF800_0000);
        apply(17, 1, 32'h0000_0001, 2, 32'd1, 0, 0, 0, 0, 1, 1);
        expect_val("R8 ror", 32'h8000_0000);
        // R9: immediate shift amount
        apply(16, 1, 32'h8000_0001, 0, 0, 1, 16'd0, 0, 5'd4, 1, 1);
        expect_val("R9 roli", 32'h0000_0018);
        // R10, R11
        apply(2, 1, 32'h0001_0000, 2, 32'h0001_0003, 0, 0, 0, 0, 1, 1);
        expect_val("R10 mul low", 32'h0003_0000);
        apply(18, 1, 32'hFFFF_FFFF, 2, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1);
        expect_val("R11 mulhss", 32'd0);
        apply(19, 1, 32'hFFFF_FFFF, 2, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1);
        expect_val("R11 mulhuu", 32'hFFFF_FFFE);
        apply(20, 1, 32'hFFFF_FFFF, 2, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 1);
        expect_val("R11 mulhsu", 32'hFFFF_FFFF);

        for (int i = 0; i < 3000; i++) begin
            logic [4:0] op;
            logic sel, hi;
            logic [31:0] av, bv;
            op  = 5'($urandom_range(0, 20));
            sel = 1'($urandom_range(0, 1));
            hi  = sel && (op >= 3 && op <= 5) && ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 4))
                0: av = 32'hFFFF_FFFF;
                1: av = 32'h8000_0000;
                default: av = $urandom;
            endcase
            bv = ($urandom_range(0, 4) == 0) ? 32'h7FFF_FFFF : $urandom;
            apply(op, 5'($urandom_range(0, 31)), av, 5'($urandom_range(0, 31)), bv,
                  sel, 16'($urandom), hi, 5'($urandom), 1'($urandom),
                  5'($urandom_range(0, 31)));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule